// File: doc/BRIEF.md
# Serial Acquisition-Settings Register Port

This block is the device side of a three-wire serial register port. A host holds an active-low select line low for one transaction, toggles a serial clock and shifts bits in on a data input. A fourth wire carries read data back to the host. All serial inputs are first synchronized to the local system clock. Edges of the serial clock are detected from the synchronized copy.

A transaction takes one of two shapes, and the first bit shifted in picks the shape. A write is a single 16-bit frame holding a flag, an address and a data byte. A read is an 8-bit header holding a flag and an address, followed by eight more serial clocks during which the block returns the addressed byte. The register file holds four acquisition settings and drives each one as a parallel output: the low and high channel-enable masks, a sample-rate divisor and a base sampling clock select.

Top module: `acq_serial_regport`

## Requirements
- R1: Serial input bits are captured on rising edges of the synchronized serial clock while select is low. The first bit captured is the most significant bit of the frame.
- R2: A frame whose first bit is 0 is a write. Frame bits 14:8 are the address and bits 7:0 are the data. The addressed register takes the data only after the 16th bit is captured, and registers change at no other time.
- R3: A frame whose first bit is 1 is a read, and header bits 6:0 are the address. On each of the next 8 rising serial clock edges, `sdo` presents the next bit of the addressed register, most significant bit first. `sdo` stays stable until the following rising edge.
- R4: Address 0x02 drives `chan_en_lo` (bit i enables channel i, channels 0 to 7). Address 0x03 drives `chan_en_hi` (bit i enables channel 8+i). Both read back their full byte.
- R5: Address 0x04 holds the divisor N on `rate_div`. The resulting rate is the base clock divided by N+1, and the register reads back as written.
- R6: Address 0x0A bit 0 drives `base_clk_sel` (0 selects the 100 MHz base, 1 selects the 160 MHz base). Its other bits are not stored, and it reads back as 0000000 followed by the stored bit.
- R7: Writes to any address other than 0x02, 0x03, 0x04 and 0x0A change no output. Reads from such addresses return 0x00.
- R8: Raising select in the middle of a frame discards the partial frame and returns the bit count to zero. The next frame is decoded from its own first bit.
- R9: After reset, all four settings are 0 and `sdo` is 0.
- R10: While select is high (after synchronization), `sdo` is driven 0.
- R11: Serial clock edges after the 16th edge of a transaction are ignored until select goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_n | input | 1 | Active-low transaction select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| chan_en_lo | output | 8 | Enable mask for channels 0 to 7 |
| chan_en_hi | output | 8 | Enable mask for channels 8 to 15 |
| rate_div | output | 8 | Sample-rate divisor N |
| base_clk_sel | output | 1 | Base sampling clock select |

## Verification
Writes and reads are issued in random mixes over the four mapped addresses and random unmapped ones, with random data. A shadow model tells apart address decode faults, bit-order faults and read-mux faults. Data such as 0x2C separates most-significant-first from reversed shifting. A 0xFF write to the clock select shows that only bit 0 is kept. A frame cut short by select and a frame padded with extra clocks show whether the bit counter is cleared and whether it saturates. Reads from unmapped addresses, and a check of `sdo` while idle, separate a zero default from stale shift data.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 8;
  localparam int HDR_W   = ADDR_W + 1;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  localparam int NUM_BYTE_REGS = 3;
  localparam logic [ADDR_W-1:0] ADDR_CH_LO  = 7'h02;
  localparam logic [ADDR_W-1:0] ADDR_CH_HI  = 7'h03;
  localparam logic [ADDR_W-1:0] ADDR_DIV    = 7'h04;
  localparam logic [ADDR_W-1:0] ADDR_CLKSEL = 7'h0A;

  function automatic logic [ADDR_W-1:0] byte_reg_addr(input int idx);
    case (idx)
      0:       return ADDR_CH_LO;
      1:       return ADDR_CH_HI;
      default: return ADDR_DIV;
    endcase
  endfunction
endpackage

// File: rtl/srp_rst_sync.sv
module srp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = din;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= RST_VAL;
      else        stage_q[g] <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/srp_frame.sv
module srp_frame
  import srp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_act,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sclk_rise,
  output logic [CNT_W-1:0]  frame_cnt,
  output logic              sdo
);
  localparam logic [CNT_W-1:0] CNT_HDR_LAST = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] CNT_FR_LAST  = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL     = CNT_W'(FRAME_W);

  logic               sclk_d_q;
  logic [FRAME_W-1:0] sh_q, sh_d, sh_nx;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               rd_mode_q, rd_mode_d;
  logic [DATA_W-1:0]  rd_sh_q, rd_sh_d;
  logic               sdo_q, sdo_d;

  assign sclk_rise = sclk_s & ~sclk_d_q;
  assign sh_nx     = {sh_q[FRAME_W-2:0], sdi_s};
  assign rd_addr   = sh_nx[ADDR_W-1:0];
  assign wr_addr   = sh_nx[FRAME_W-2 -: ADDR_W];
  assign wr_data   = sh_nx[DATA_W-1:0];

  always_comb begin
    sh_d      = sh_q;
    cnt_d     = cnt_q;
    rd_mode_d = rd_mode_q;
    rd_sh_d   = rd_sh_q;
    sdo_d     = sdo_q;
    wr_en     = 1'b0;
    if (!sel_act) begin
      sh_d      = '0;
      cnt_d     = '0;
      rd_mode_d = 1'b0;
      rd_sh_d   = '0;
      sdo_d     = 1'b0;
    end else if (sclk_rise && (cnt_q != CNT_FULL)) begin
      cnt_d = cnt_q + 1'b1;
      if (rd_mode_q) begin
        sdo_d   = rd_sh_q[DATA_W-1];
        rd_sh_d = {rd_sh_q[DATA_W-2:0], 1'b0};
      end else begin
        sh_d = sh_nx;
        if ((cnt_q == CNT_HDR_LAST) && sh_nx[HDR_W-1]) begin
          rd_mode_d = 1'b1;
          rd_sh_d   = rd_data;
        end
        if (cnt_q == CNT_FR_LAST) wr_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q  <= 1'b0;
      sh_q      <= '0;
      cnt_q     <= '0;
      rd_mode_q <= 1'b0;
      rd_sh_q   <= '0;
      sdo_q     <= 1'b0;
    end else begin
      sclk_d_q  <= sclk_s;
      sh_q      <= sh_d;
      cnt_q     <= cnt_d;
      rd_mode_q <= rd_mode_d;
      rd_sh_q   <= rd_sh_d;
      sdo_q     <= sdo_d;
    end
  end

  assign frame_cnt = cnt_q;
  assign sdo       = sdo_q;
endmodule

// File: rtl/srp_regfile.sv
module srp_regfile
  import srp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] chan_en_lo,
  output logic [DATA_W-1:0] chan_en_hi,
  output logic [DATA_W-1:0] rate_div,
  output logic              base_clk_sel
);
  logic [DATA_W-1:0] byte_q [NUM_BYTE_REGS];
  logic              clksel_q, clksel_d;

  for (genvar g = 0; g < NUM_BYTE_REGS; g++) begin : g_byte
    localparam logic [ADDR_W-1:0] MY_ADDR = byte_reg_addr(g);
    logic [DATA_W-1:0] byte_d;
    always_comb byte_d = (wr_en && (wr_addr == MY_ADDR)) ? wr_data : byte_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q[g] <= '0;
      else        byte_q[g] <= byte_d;
    end
  end

  always_comb clksel_d = (wr_en && (wr_addr == ADDR_CLKSEL)) ? wr_data[0] : clksel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clksel_q <= 1'b0;
    else        clksel_q <= clksel_d;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_BYTE_REGS; i++) begin
      if (rd_addr == byte_reg_addr(i)) rd_data = byte_q[i];
    end
    if (rd_addr == ADDR_CLKSEL) rd_data = {{(DATA_W-1){1'b0}}, clksel_q};
  end

  assign chan_en_lo   = byte_q[0];
  assign chan_en_hi   = byte_q[1];
  assign rate_div     = byte_q[2];
  assign base_clk_sel = clksel_q;
endmodule

// File: rtl/acq_serial_regport.sv
module acq_serial_regport
  import srp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic [DATA_W-1:0] chan_en_lo,
  output logic [DATA_W-1:0] chan_en_hi,
  output logic [DATA_W-1:0] rate_div,
  output logic              base_clk_sel
);
  logic              rst_n_i;
  logic [2:0]        pins_s;
  logic              sel_act;
  logic              sclk_rise;
  logic [CNT_W-1:0]  frame_cnt;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  srp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n(rst_n_i)
  );

  srp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n_i), .din({sel_n, sclk, sdi}), .dout(pins_s)
  );

  assign sel_act = ~pins_s[2];

  srp_frame u_frame (
    .clk(clk), .rst_n(rst_n_i), .sel_act(sel_act), .sclk_s(pins_s[1]),
    .sdi_s(pins_s[0]), .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sclk_rise(sclk_rise),
    .frame_cnt(frame_cnt), .sdo(sdo)
  );

  srp_regfile u_regs (
    .clk(clk), .rst_n(rst_n_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .chan_en_lo(chan_en_lo), .chan_en_hi(chan_en_hi), .rate_div(rate_div),
    .base_clk_sel(base_clk_sel)
  );
endmodule

// File: rtl/srp_checker.sv
module srp_checker
  import srp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sel_act,
  input logic              sclk_rise,
  input logic              wr_en,
  input logic [CNT_W-1:0]  frame_cnt,
  input logic              sdo,
  input logic [DATA_W-1:0] chan_en_lo,
  input logic [DATA_W-1:0] chan_en_hi,
  input logic [DATA_W-1:0] rate_div,
  input logic              base_clk_sel
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    frame_cnt <= CNT_FULL); // R11

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_act |=> (frame_cnt == '0)); // R8

  AST_WRITE_AT_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (frame_cnt == CNT_FULL)); // R2

  AST_REGS_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({chan_en_lo, chan_en_hi, rate_div, base_clk_sel})); // R2

  AST_SDO_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_act |=> !sdo); // R10

  AST_SDO_MOVES_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(sclk_rise || !sel_act)); // R3
endmodule

bind acq_serial_regport srp_checker u_chk (
  .clk(clk), .rst_n(rst_n_i), .sel_act(sel_act), .sclk_rise(sclk_rise),
  .wr_en(wr_en), .frame_cnt(frame_cnt), .sdo(sdo), .chan_en_lo(chan_en_lo),
  .chan_en_hi(chan_en_hi), .rate_div(rate_div), .base_clk_sel(base_clk_sel)
);

// File: tb/acq_serial_regport_bench.sv
module acq_serial_regport_bench;
  localparam int HP = 6;

  logic clk = 1'b0;
  logic rst_n, sel_n, sclk, sdi;
  logic sdo, base_clk_sel;
  logic [7:0] chan_en_lo, chan_en_hi, rate_div;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] m_lo = 8'h00, m_hi = 8'h00, m_div = 8'h00;
  logic       m_sel = 1'b0;

  always #5 clk = ~clk;

  acq_serial_regport u_acq_serial_regport (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .chan_en_lo(chan_en_lo), .chan_en_hi(chan_en_hi), .rate_div(rate_div),
    .base_clk_sel(base_clk_sel)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [6:0] a);
    case (a)
      7'h02:   return m_lo;
      7'h03:   return m_hi;
      7'h04:   return m_div;
      7'h0A:   return {7'b0, m_sel};
      default: return 8'h00;
    endcase
  endfunction

  function automatic void model_write(input logic [6:0] a, input logic [7:0] d);
    case (a)
      7'h02: m_lo = d;
      7'h03: m_hi = d;
      7'h04: m_div = d;
      7'h0A: m_sel = d[0];
      default: ;
    endcase
  endfunction

  task automatic pulse(input logic b);
    sdi = b;
    wait_cyc(HP);
    sclk = 1'b1;
    wait_cyc(HP);
    sclk = 1'b0;
  endtask

  task automatic open_frame();
    sel_n = 1'b0;
    wait_cyc(HP);
  endtask

  task automatic close_frame();
    wait_cyc(HP);
    sel_n = 1'b1;
    wait_cyc(8);
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int i = 15; i > 15 - n; i--) pulse(v[i]);
  endtask

  task automatic write_reg(input logic [6:0] a, input logic [7:0] d);
    open_frame();
    send_bits({1'b0, a, d}, 16);
    close_frame();
    model_write(a, d);
  endtask

  task automatic read_reg(input logic [6:0] a, output logic [7:0] d);
    open_frame();
    send_bits({1'b1, a, 8'h00}, 8);
    for (int i = 7; i >= 0; i--) begin
      sdi = 1'b0;
      wait_cyc(HP);
      sclk = 1'b1;
      wait_cyc(HP);
      sclk = 1'b0;
      wait_cyc(2);
      d[i] = sdo;
      wait_cyc(HP - 2);
    end
    close_frame();
  endtask

  task automatic check_outputs(input string req);
    check({req, " chan_en_lo"}, {24'h0, chan_en_lo}, {24'h0, m_lo});
    check({req, " chan_en_hi"}, {24'h0, chan_en_hi}, {24'h0, m_hi});
    check({req, " rate_div"}, {24'h0, rate_div}, {24'h0, m_div});
    check({req, " base_clk_sel"}, {31'h0, base_clk_sel}, {31'h0, m_sel});
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'd7151));
    rst_n = 1'b0; sel_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    wait_cyc(5);
    check("R9 sdo in reset", {31'h0, sdo}, 32'h0);
    rst_n = 1'b1;
    wait_cyc(6);
    check_outputs("R9 after reset");
    check("R9 sdo after reset", {31'h0, sdo}, 32'h0);

    // R1: asymmetric pattern exposes bit order
    write_reg(7'h04, 8'h2C);
    check("R1 msb-first rate_div", {24'h0, rate_div}, 32'h2C);
    read_reg(7'h04, rd);
    check("R5 readback divisor", {24'h0, rd}, 32'h2C);

    // R4 channel masks
    write_reg(7'h02, 8'hA5);
    write_reg(7'h03, 8'h3C);
    check_outputs("R4 masks");
    read_reg(7'h03, rd);
    check("R4 readback hi", {24'h0, rd}, 32'h3C);

    // R6 only bit 0 kept
    write_reg(7'h0A, 8'hFF);
    check("R6 clk select set", {31'h0, base_clk_sel}, 32'h1);
    read_reg(7'h0A, rd);
    check("R6 readback", {24'h0, rd}, 32'h01);
    write_reg(7'h0A, 8'hFE);
    check("R6 clk select cleared by bit0", {31'h0, base_clk_sel}, 32'h0);

    // R7 unmapped
    write_reg(7'h05, 8'h77);
    check_outputs("R7 unmapped write");
    read_reg(7'h7F, rd);
    check("R7 unmapped read", {24'h0, rd}, 32'h00);

    // R8 aborted frame, then a clean frame
    open_frame();
    send_bits({1'b0, 7'h04, 8'h55}, 12);
    close_frame();
    check_outputs("R8 partial frame discarded");
    write_reg(7'h04, 8'h91);
    check_outputs("R8 restart after abort");

    // R11 extra clocks after 16 bits
    open_frame();
    send_bits({1'b0, 7'h02, 8'h4E}, 16);
    send_bits(16'hF000, 4);
    close_frame();
    model_write(7'h02, 8'h4E);
    check_outputs("R11 extra clocks ignored");

    // R10 idle sdo after a read whose last bit was 1
    write_reg(7'h03, 8'hFF);
    read_reg(7'h03, rd);
    check("R3 read all ones", {24'h0, rd}, 32'hFF);
    check("R10 sdo idle", {31'h0, sdo}, 32'h0);

    // Random mix (R2, R3)
    for (int k = 0; k < 48; k++) begin
      logic [6:0] a;
      logic [7:0] d;
      int pick;
      pick = int'($urandom % 6);
      case (pick)
        0: a = 7'h02;
        1: a = 7'h03;
        2: a = 7'h04;
        3: a = 7'h0A;
        default: a = 7'($urandom);
      endcase
      d = 8'($urandom);
      if ($urandom % 2 == 0) begin
        write_reg(a, d);
        check_outputs("R2 random write");
      end else begin
        read_reg(a, rd);
        check("R3 random read", {24'h0, rd}, {24'h0, exp_read(a)});
      end
    end

    done = 1'b1;
    report();
    $finish;
  end
endmodule